// File: doc/BRIEF.md
# 64-bit ALU with Condition Flags

This block is a 64-bit arithmetic and logic unit that produces its result combinationally and keeps four condition flags in registers: zero, overflow, sign and carry. The first operand (X) is either a register value or an 8-bit immediate. The second operand (Y) always comes from a register. A 3-bit operation code selects one of eight operations: add, subtract (Y minus X), low-half unsigned multiply, bitwise OR, bitwise AND, logical shift left, logical shift right, and load of a 16-bit constant.

Each operation class has its own flag policy:

- Add and subtract rewrite all four flags.
- OR and AND rewrite only the zero flag.
- Shifts, multiply and load-immediate leave every flag as it was.

The flags are captured on a rising clock edge only when the enable input is high. A decode stage sits in front of the block, and a register file sits around it. The decode stage drives the operands and the enable. It writes `result_o` back to the register file and uses the flags for conditional branches.

Top module: `alu64_flags`

## Requirements
- R1: `op_i` selects the operation as follows: 0 add, 1 subtract, 2 multiply, 3 OR, 4 AND, 5 shift left, 6 shift right, 7 load-immediate. `result_o` follows the current inputs combinationally.
- R2: With `imm_sel_i`=0, operand X is `reg_x_i`. With `imm_sel_i`=1, operand X is `imm_i`. The immediate is sign-extended for add and subtract and zero-extended for every other operation.
- R3: Add returns X+Y modulo 2^64 and sets the flags as follows:
  - CF when the sum is below either operand.
  - ZF when the sum is zero.
  - SF from bit 63 of the sum.
  - OF when X and Y share a sign that the sum does not.
- R4: Subtract returns Y−X and sets the flags as follows:
  - ZF, SF and OF as for adding Y to the two's complement of X.
  - CF when the result is greater than Y as unsigned values (a borrow).
- R5: OR and AND return the bitwise result. They set ZF when the result is zero and leave OF, SF and CF unchanged.
- R6: Shift left and shift right move Y by X bit positions, filling with zeros. A shift amount of 64 or more gives zero. Neither shift changes any flag.
- R7: Multiply returns the low 64 bits of X·Y as unsigned values and changes no flag.
- R8: Load-immediate returns `ldi_val_i` zero-extended to 64 bits. It ignores both operands and changes no flag.
- R9: The flags update only on a rising clock edge where `en_i` is 1. When `en_i` is 0, the flags hold regardless of the operation.
- R10: `rst_ni` low clears all four flags to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Commit the flags of this operation |
| op_i | input | 3 | Operation code |
| imm_sel_i | input | 1 | Take operand X from the immediate |
| imm_i | input | 8 | 8-bit immediate |
| reg_x_i | input | 64 | Register operand X |
| reg_y_i | input | 64 | Register operand Y |
| ldi_val_i | input | 16 | Constant for load-immediate |
| result_o | output | 64 | Operation result |
| zf_o | output | 1 | Zero flag |
| of_o | output | 1 | Signed overflow flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Carry / borrow flag |

## Verification
The only state in the block is the four flag bits, so any wrong internal state shows on `zf_o`, `of_o`, `sf_o` or `cf_o` one clock edge after the operation that should have set them. The bench compares the flags at the negative edge after each enabled or disabled cycle. It also checks that flags survive the operations that must not touch them, because a policy error can hide until a later add or logic operation would have overwritten them. Errors in operand extension and in the result show on `result_o` in the same cycle.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_OR  = 3'd3,
    OP_AND = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_LDI = 3'd7
  } alu_op_e;

  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned FLAG_Z = 3;
  localparam int unsigned FLAG_O = 2;
  localparam int unsigned FLAG_S = 1;
  localparam int unsigned FLAG_C = 0;

  localparam logic [NUM_FLAGS-1:0] UPD_ALL  = 4'b1111;
  localparam logic [NUM_FLAGS-1:0] UPD_ZERO = 4'b1000;
  localparam logic [NUM_FLAGS-1:0] UPD_NONE = 4'b0000;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import alu64_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned IW = 8
) (
  input  alu_op_e       op_i,
  input  logic          imm_sel_i,
  input  logic [IW-1:0] imm_i,
  input  logic [DW-1:0] reg_x_i,
  output logic [DW-1:0] opx_o
);
  localparam int unsigned EXT_W = DW - IW;

  logic          sext_en;
  logic [DW-1:0] imm_ext;

  // arithmetic takes a signed immediate, the rest an unsigned one
  assign sext_en = (op_i == OP_ADD) || (op_i == OP_SUB);
  assign imm_ext = {{EXT_W{sext_en & imm_i[IW-1]}}, imm_i};
  assign opx_o   = imm_sel_i ? imm_ext : reg_x_i;
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          zf_o,
  output logic          of_o,
  output logic          sf_o,
  output logic          cf_o
);
  logic [DW-1:0] addend;
  logic [DW-1:0] sum;
  logic          add_carry;
  logic          sub_borrow;

  assign addend     = sub_i ? (~x_i + {{(DW-1){1'b0}}, 1'b1}) : x_i;
  assign sum        = y_i + addend;
  assign add_carry  = (sum < x_i) || (sum < y_i);
  assign sub_borrow = (sum > y_i);

  assign res_o = sum;
  assign zf_o  = (sum == '0);
  assign sf_o  = sum[DW-1];
  assign of_o  = (addend[DW-1] == y_i[DW-1]) && (sum[DW-1] != y_i[DW-1]);
  assign cf_o  = sub_i ? sub_borrow : add_carry;
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu64_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned SHW = $clog2(DW);

  logic [SHW-1:0] shamt;
  logic           over_shift;
  logic [DW-1:0]  shl_res;
  logic [DW-1:0]  shr_res;
  logic [DW-1:0]  mul_res;

  assign shamt      = x_i[SHW-1:0];
  assign over_shift = |x_i[DW-1:SHW];
  assign shl_res    = over_shift ? '0 : (y_i << shamt);
  assign shr_res    = over_shift ? '0 : (y_i >> shamt);
  assign mul_res    = x_i * y_i;

  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = x_i | y_i;
      OP_AND:  res_o = x_i & y_i;
      OP_SHL:  res_o = shl_res;
      OP_SHR:  res_o = shr_res;
      OP_MUL:  res_o = mul_res;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg #(
  parameter int unsigned NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NF-1:0] upd_i,
  input  logic [NF-1:0] nxt_i,
  output logic [NF-1:0] q_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q_o[g] <= 1'b0;
      else if (en_i && upd_i[g])   q_o[g] <= nxt_i[g];
    end
  end
endmodule

// File: rtl/alu64_flags.sv
module alu64_flags
  import alu64_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned LDI_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        op_i,
  input  logic              imm_sel_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] reg_x_i,
  input  logic [DATA_W-1:0] reg_y_i,
  input  logic [LDI_W-1:0]  ldi_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zf_o,
  output logic              of_o,
  output logic              sf_o,
  output logic              cf_o
);
  alu_op_e               op;
  logic [DATA_W-1:0]     opx;
  logic [DATA_W-1:0]     arith_res;
  logic [DATA_W-1:0]     bit_res;
  logic                  a_zf, a_of, a_sf, a_cf;
  logic                  is_arith;
  logic [NUM_FLAGS-1:0]  upd_mask;
  logic [NUM_FLAGS-1:0]  nxt_flags;
  logic [NUM_FLAGS-1:0]  flags_q;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  alu_opnd_sel #(.DW(DATA_W), .IW(IMM_W)) u_opnd (
    .op_i     (op),
    .imm_sel_i(imm_sel_i),
    .imm_i    (imm_i),
    .reg_x_i  (reg_x_i),
    .opx_o    (opx)
  );

  alu_arith #(.DW(DATA_W)) u_arith (
    .x_i  (opx),
    .y_i  (reg_y_i),
    .sub_i(op == OP_SUB),
    .res_o(arith_res),
    .zf_o (a_zf),
    .of_o (a_of),
    .sf_o (a_sf),
    .cf_o (a_cf)
  );

  alu_bitops #(.DW(DATA_W)) u_bitops (
    .op_i (op),
    .x_i  (opx),
    .y_i  (reg_y_i),
    .res_o(bit_res)
  );

  always_comb begin
    if (is_arith)          result_o = arith_res;
    else if (op == OP_LDI) result_o = {{(DATA_W-LDI_W){1'b0}}, ldi_val_i};
    else                   result_o = bit_res;
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: upd_mask = UPD_ALL;
      OP_OR, OP_AND:  upd_mask = UPD_ZERO;
      default:        upd_mask = UPD_NONE;
    endcase
  end

  always_comb begin
    nxt_flags         = '0;
    nxt_flags[FLAG_Z] = is_arith ? a_zf : (bit_res == '0);
    nxt_flags[FLAG_O] = a_of;
    nxt_flags[FLAG_S] = a_sf;
    nxt_flags[FLAG_C] = a_cf;
  end

  alu_flag_reg #(.NF(NUM_FLAGS)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .upd_i (upd_mask),
    .nxt_i (nxt_flags),
    .q_o   (flags_q)
  );

  assign zf_o = flags_q[FLAG_Z];
  assign of_o = flags_q[FLAG_O];
  assign sf_o = flags_q[FLAG_S];
  assign cf_o = flags_q[FLAG_C];
endmodule

// File: rtl/alu64_flags_chk.sv
module alu64_flags_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned LDI_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [2:0]        op_i,
  input logic              imm_sel_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] reg_x_i,
  input logic [DATA_W-1:0] reg_y_i,
  input logic [LDI_W-1:0]  ldi_val_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zf_o,
  input logic              of_o,
  input logic              sf_o,
  input logic              cf_o
);
  localparam int unsigned SHW = $clog2(DATA_W);

  // R9
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({zf_o, of_o, sf_o, cf_o}));

  // R6
  shift_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == 3'd5 || op_i == 3'd6) |=> $stable({zf_o, of_o, sf_o, cf_o}));

  // R6
  big_shift_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 || op_i == 3'd6) && !imm_sel_i && (|reg_x_i[DATA_W-1:SHW])
    |-> result_o == '0);

  // R7
  mul_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == 3'd2 |=> $stable({zf_o, of_o, sf_o, cf_o}));

  // R8
  ldi_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && op_i == 3'd7 |=> $stable({zf_o, of_o, sf_o, cf_o}));

  // R8
  ldi_zero_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd7 |-> result_o[DATA_W-1:LDI_W] == '0);

  // R5
  logic_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == 3'd3 || op_i == 3'd4) |=> $stable({of_o, sf_o, cf_o}));

  // R5
  logic_zf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == 3'd3 || op_i == 3'd4) |=> zf_o == $past(result_o == '0));

  // R3
  arith_sf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (op_i == 3'd0 || op_i == 3'd1) |=> sf_o == $past(result_o[DATA_W-1]));

  // R10
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !(zf_o || of_o || sf_o || cf_o));
endmodule

bind alu64_flags alu64_flags_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .LDI_W(LDI_W)
) chk_i (.*);

// File: tb/alu64_flags_tb_top.sv
`timescale 1ns/1ps
module alu64_flags_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        en_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic        imm_sel_i = 1'b0;
  logic [7:0]  imm_i = 8'd0;
  logic [63:0] reg_x_i = '0;
  logic [63:0] reg_y_i = '0;
  logic [15:0] ldi_val_i = '0;
  logic [63:0] result_o;
  logic        zf_o, of_o, sf_o, cf_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_f = 4'b0000; // {z,o,s,c}

  always #4 clk_i = ~clk_i; // 125 MHz

  alu64_flags dut_i (.*);

  task automatic check64(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    n_chk++;
    if ({zf_o, of_o, sf_o, cf_o} !== exp_f) begin
      n_fail++;
      $display("FAIL %s flags zosc act=%b exp=%b", tag, {zf_o, of_o, sf_o, cf_o}, exp_f);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op, input logic isel);
    string t;
    case (op)
      3'd0: t = "R3";
      3'd1: t = "R4";
      3'd2: t = "R7";
      3'd3, 3'd4: t = "R5";
      3'd5, 3'd6: t = "R6";
      default: t = "R8";
    endcase
    return isel ? {t, "/R2"} : {t, "/R1"};
  endfunction

  // reference model: result plus updated flags
  task automatic model(input logic [2:0] op, input logic isel, input logic [7:0] imm,
                       input logic [63:0] rx, input logic [63:0] ry, input logic [15:0] lv,
                       input logic [3:0] f_in, output logic [63:0] r, output logic [3:0] f_out);
    logic [63:0] x;
    logic [64:0] wide;
    logic [63:0] nx;
    f_out = f_in;
    if (!isel) x = rx;
    else if (op <= 3'd1) x = {{56{imm[7]}}, imm};
    else x = {56'd0, imm};
    case (op)
      3'd0: begin
        wide = {1'b0, x} + {1'b0, ry};
        r = wide[63:0];
        f_out = {r == 0, (x[63] == ry[63]) && (r[63] != x[63]), r[63], wide[64]};
      end
      3'd1: begin
        nx = -x;
        r = ry - x;
        f_out = {r == 0, (nx[63] == ry[63]) && (r[63] != ry[63]), r[63], r > ry};
      end
      3'd2: r = x * ry;
      3'd3: begin r = x | ry; f_out[3] = (r == 0); end
      3'd4: begin r = x & ry; f_out[3] = (r == 0); end
      3'd5: r = (x > 64'd63) ? 64'd0 : ry << x;
      3'd6: r = (x > 64'd63) ? 64'd0 : ry >> x;
      default: r = {48'd0, lv};
    endcase
  endtask

  task automatic do_op(input logic [2:0] op, input logic isel, input logic [7:0] imm,
                       input logic [63:0] rx, input logic [63:0] ry, input logic [15:0] lv,
                       input logic en);
    logic [63:0] er;
    logic [3:0]  ef;
    string tag;
    @(negedge clk_i);
    op_i = op; imm_sel_i = isel; imm_i = imm; reg_x_i = rx; reg_y_i = ry;
    ldi_val_i = lv; en_i = en;
    #1;
    model(op, isel, imm, rx, ry, lv, exp_f, er, ef);
    tag = en ? tag_of(op, isel) : "R9";
    check64(result_o, er, tag);
    @(negedge clk_i);
    if (en) exp_f = ef;
    check_flags(tag);
    en_i = 1'b0;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    #20;
    // R10: reset state
    check_flags("R10");
    @(negedge clk_i) rst_ni = 1'b1;

    // R3 directed: carry and zero, then signed overflow
    do_op(3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);
    do_op(3'd0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);
    // R5: OR keeps OF/SF, zero result sets ZF
    do_op(3'd3, 0, 0, 64'd0, 64'd0, 0, 1);
    // R6/R7/R8: no flag change
    do_op(3'd5, 0, 0, 64'd64, 64'hDEAD, 0, 1);
    do_op(3'd6, 0, 0, 64'd63, 64'h8000_0000_0000_0000, 0, 1);
    do_op(3'd5, 0, 0, 64'h1_0000_0000, 64'hFFFF, 0, 1);
    do_op(3'd2, 1, 8'hFF, 64'd0, 64'd3, 0, 1);
    do_op(3'd7, 0, 0, 64'hFFFF, 64'hFFFF, 16'hBEEF, 1);
    // R4: borrow and no borrow, most negative X
    do_op(3'd1, 0, 0, 64'd5, 64'd3, 0, 1);
    do_op(3'd1, 0, 0, 64'd3, 64'd5, 0, 1);
    do_op(3'd1, 0, 0, 64'h8000_0000_0000_0000, 64'd0, 0, 1);
    // R2: immediate sign extension for SUB, zero extension for AND
    do_op(3'd1, 1, 8'hFF, 0, 64'd0, 0, 1);
    do_op(3'd4, 1, 8'hF0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1);
    do_op(3'd0, 1, 8'h80, 0, 64'd128, 0, 1);
    // R9: disabled add leaves flags
    do_op(3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0);

    // constrained random
    void'($urandom(32'd20240601));
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  op;
      logic [63:0] rx;
      logic [63:0] ry;
      op = 3'($urandom_range(0, 7));
      rx = {$urandom, $urandom};
      ry = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) rx = 64'($urandom_range(0, 70));
      if ($urandom_range(0, 7) == 0) ry = -rx;
      do_op(op, 1'($urandom_range(0, 1)), 8'($urandom), rx, ry, 16'($urandom),
            $urandom_range(0, 4) != 0);
    end

    // R10: asynchronous reset mid-run
    do_op(3'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 1);
    #2 rst_ni = 1'b0;
    #1 exp_f = 4'b0000;
    check_flags("R10");
    @(negedge clk_i) rst_ni = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule